// File: doc/BRIEF.md
# FSK Fractional Divide Word Selector

This block stores three programmed divide ratios for a fractional-N frequency synthesizer: a center ratio, a mark ratio and a space ratio. It presents the ratio currently in use to the divider and converts it into a whole-number divide value for every reference cycle. The conversion uses a first-order fractional accumulator. Each ratio is a 16-bit fixed-point word with 4 integer bits and 12 fractional bits. The frequency step is therefore the reference frequency divided by 4096.

In amplitude-keyed operation the center ratio is always used. In frequency-keyed operation the data bit picks the mark ratio (data 1) or the space ratio (data 0).

Software loads each ratio as two bytes through a byte-write port. A new ratio takes effect only when its upper byte is written. A ratio whose integer part falls outside the legal synthesizer range is refused.

The selection is held in a small state machine with three states:
- CENTER: the center ratio is in use.
- MARK: the mark ratio is in use.
- SPACE: the space ratio is in use.

On every clock, which is the reference cycle, the machine moves to the state named by the inputs sampled at that edge, from any state:
- to CENTER when `keying_fsk` is 0;
- to MARK when `keying_fsk` is 1 and `tx_bit` is 1;
- to SPACE when `keying_fsk` is 1 and `tx_bit` is 0.

Reset puts it in CENTER.

Top module: `fdw_selector`

## Requirements
- R1: While `rst_n` is low and after it is released, all three ratios hold 0x8000 (24.0), the state is CENTER, `ratio_word` reads 0x8000, `div_value` reads 24 and the accumulator is 0.
- R2: A ratio word is coded as 4.12 fixed point: bits 15..12 hold the integer part minus 16, and bits 11..0 hold the fraction in units of 1/4096. With a fraction of 1, exactly one of every 4096 consecutive divide values is raised by one.
- R3: Byte addresses are: center low 0, center high 1, mark low 2, mark high 3, space low 4, space high 5. Writes to addresses 6 and 7 change no ratio.
- R4: Writing a low byte only stages it; the ratio in use is unchanged on the following cycles.
- R5: Writing a high byte replaces the ratio with {high byte, last staged low byte} for that slot, visible on `ratio_word` after that clock edge when the slot is selected.
- R6: A high byte whose bits 7..4 are below 3 or above 12 (integer part outside 19..28) is ignored, and the stored ratio stays as it was.
- R7: With `keying_fsk` = 0 sampled at an edge, `ratio_word` shows the center ratio after that edge.
- R8: With `keying_fsk` = 1 sampled at an edge, `ratio_word` shows the mark ratio when `tx_bit` was 1 and the space ratio when it was 0.
- R9: Changes of `keying_fsk` or `tx_bit` affect `ratio_word` only after the next clock edge.
- R10: At each edge a 12-bit accumulator adds the fraction of the word shown before the edge. `div_value` becomes 16 + integer field + carry out. The accumulator is not cleared when the selected ratio changes.
- R11: `div_value` always lies between 19 and 29.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one cycle per reference period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Byte write strobe |
| cfg_addr | input | 3 | Byte address (see R3) |
| cfg_wdata | input | 8 | Byte write data |
| keying_fsk | input | 1 | 1 = frequency keying, 0 = amplitude keying |
| tx_bit | input | 1 | Transmit data bit |
| ratio_word | output | 16 | 4.12 ratio currently selected |
| div_value | output | 5 | Whole divide value for this reference cycle |

## Verification
The hardest case to reach from the ports is the accumulator overflow at the top of the range, where the integer part is 28 and the carry pushes `div_value` to 29. With random fractions this happens rarely and at unpredictable times. A directed phase therefore loads a ratio with a fraction of one and runs exactly 4096 cycles, which must hold exactly one raised value. Staged-but-uncommitted low bytes and refused high bytes are mixed into a long seeded random run. In that run the bench model follows every slot, so a later commit exposes a stale or wrongly kept staging byte.

// File: rtl/fdw_pkg.sv
package fdw_pkg;
    typedef enum logic [1:0] {
        ST_CENTER = 2'd0,
        ST_MARK   = 2'd1,
        ST_SPACE  = 2'd2
    } fdw_state_e;

    localparam int SLOT_CENTER = 0;
    localparam int SLOT_MARK   = 1;
    localparam int SLOT_SPACE  = 2;
    localparam int NUM_SLOTS   = 3;
endpackage

// File: rtl/fdw_bank.sv
module fdw_bank #(
    parameter int INT_W      = 4,
    parameter int FRAC_W     = 12,
    parameter int INT_OFFSET = 16,
    parameter int INT_MIN    = 19,
    parameter int INT_MAX    = 28,
    parameter int RESET_INT  = 24,
    parameter int NUM_RATIO  = 3,
    parameter int ADDR_W     = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [ADDR_W-1:0]                      wr_addr,
    input  logic [(INT_W+FRAC_W)/2-1:0]            wr_data,
    output logic [NUM_RATIO-1:0][INT_W+FRAC_W-1:0] words
);
    localparam int WORD_W = INT_W + FRAC_W;
    localparam int BYTE_W = WORD_W / 2;
    localparam logic [INT_W-1:0]  FLD_MIN    = INT_W'(INT_MIN - INT_OFFSET);
    localparam logic [INT_W-1:0]  FLD_MAX    = INT_W'(INT_MAX - INT_OFFSET);
    localparam logic [WORD_W-1:0] RESET_WORD = WORD_W'(RESET_INT - INT_OFFSET) << FRAC_W;

    logic [INT_W-1:0]  hi_field;
    logic              hi_legal;
    logic [ADDR_W-2:0] slot;
    logic              is_hi;

    assign hi_field = wr_data[BYTE_W-1 -: INT_W];
    assign hi_legal = (hi_field >= FLD_MIN) && (hi_field <= FLD_MAX);
    assign slot     = wr_addr[ADDR_W-1:1];
    assign is_hi    = wr_addr[0];

    for (genvar gi = 0; gi < NUM_RATIO; gi++) begin : g_slot
        localparam logic [ADDR_W-2:0] SLOT_ID = (ADDR_W-1)'(gi);
        logic [BYTE_W-1:0] stage_q;
        logic [WORD_W-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= RESET_WORD[BYTE_W-1:0];
                word_q  <= RESET_WORD;
            end else if (wr_en && (slot == SLOT_ID)) begin
                if (!is_hi) begin
                    stage_q <= wr_data;
                end else if (hi_legal) begin
                    word_q <= {wr_data, stage_q};
                end
            end
        end

        assign words[gi] = word_q;
    end
endmodule

// File: rtl/fdw_mode_fsm.sv
module fdw_mode_fsm
    import fdw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       keying_fsk,
    input  logic       tx_bit,
    output logic [1:0] sel_idx
);
    fdw_state_e state_q, state_d;

    always_comb begin
        if (!keying_fsk) begin
            state_d = ST_CENTER;
        end else if (tx_bit) begin
            state_d = ST_MARK;
        end else begin
            state_d = ST_SPACE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CENTER;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_CENTER: sel_idx = 2'(SLOT_CENTER);
            ST_MARK:   sel_idx = 2'(SLOT_MARK);
            ST_SPACE:  sel_idx = 2'(SLOT_SPACE);
            default:   sel_idx = 2'(SLOT_CENTER);
        endcase
    end
endmodule

// File: rtl/fdw_accum.sv
module fdw_accum #(
    parameter int INT_W      = 4,
    parameter int FRAC_W     = 12,
    parameter int INT_OFFSET = 16,
    parameter int RESET_INT  = 24,
    parameter int DIV_W      = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [INT_W+FRAC_W-1:0] word,
    output logic [DIV_W-1:0]        div_int
);
    localparam int WORD_W = INT_W + FRAC_W;

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;
    logic [DIV_W-1:0]  div_d;

    assign sum   = {1'b0, acc_q} + {1'b0, word[FRAC_W-1:0]};
    assign div_d = DIV_W'(INT_OFFSET) + DIV_W'(word[WORD_W-1:FRAC_W]) + DIV_W'(sum[FRAC_W]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            div_int <= DIV_W'(RESET_INT);
        end else begin
            acc_q   <= sum[FRAC_W-1:0];
            div_int <= div_d;
        end
    end
endmodule

// File: rtl/fdw_selector.sv
module fdw_selector
    import fdw_pkg::*;
#(
    parameter int INT_W      = 4,
    parameter int FRAC_W     = 12,
    parameter int INT_OFFSET = 16,
    parameter int INT_MIN    = 19,
    parameter int INT_MAX    = 28,
    parameter int RESET_INT  = 24,
    parameter int ADDR_W     = 3,
    parameter int DIV_W      = $clog2(INT_MAX + 2)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [(INT_W+FRAC_W)/2-1:0] cfg_wdata,
    input  logic                        keying_fsk,
    input  logic                        tx_bit,
    output logic [INT_W+FRAC_W-1:0]     ratio_word,
    output logic [DIV_W-1:0]            div_value
);
    localparam int WORD_W = INT_W + FRAC_W;

    logic [NUM_SLOTS-1:0][WORD_W-1:0] words;
    logic [WORD_W-1:0] ctr_word, mark_word, space_word;
    logic [1:0]        sel_idx;

    fdw_bank #(
        .INT_W(INT_W), .FRAC_W(FRAC_W), .INT_OFFSET(INT_OFFSET),
        .INT_MIN(INT_MIN), .INT_MAX(INT_MAX), .RESET_INT(RESET_INT),
        .NUM_RATIO(NUM_SLOTS), .ADDR_W(ADDR_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
        .wr_data(cfg_wdata), .words(words)
    );

    assign ctr_word   = words[SLOT_CENTER];
    assign mark_word  = words[SLOT_MARK];
    assign space_word = words[SLOT_SPACE];

    fdw_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .keying_fsk(keying_fsk),
        .tx_bit(tx_bit), .sel_idx(sel_idx)
    );

    always_comb begin
        unique case (sel_idx)
            2'(SLOT_MARK):  ratio_word = mark_word;
            2'(SLOT_SPACE): ratio_word = space_word;
            default:        ratio_word = ctr_word;
        endcase
    end

    fdw_accum #(
        .INT_W(INT_W), .FRAC_W(FRAC_W), .INT_OFFSET(INT_OFFSET),
        .RESET_INT(RESET_INT), .DIV_W(DIV_W)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .word(ratio_word), .div_int(div_value)
    );
endmodule

// File: rtl/fdw_selector_chk.sv
module fdw_selector_chk #(
    parameter int INT_W      = 4,
    parameter int FRAC_W     = 12,
    parameter int INT_OFFSET = 16,
    parameter int INT_MIN    = 19,
    parameter int INT_MAX    = 28,
    parameter int ADDR_W     = 3,
    parameter int DIV_W      = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cfg_we,
    input logic [ADDR_W-1:0]           cfg_addr,
    input logic [(INT_W+FRAC_W)/2-1:0] cfg_wdata,
    input logic                        keying_fsk,
    input logic                        tx_bit,
    input logic [INT_W+FRAC_W-1:0]     ratio_word,
    input logic [DIV_W-1:0]            div_value,
    input logic [INT_W+FRAC_W-1:0]     ctr_word,
    input logic [INT_W+FRAC_W-1:0]     mark_word,
    input logic [INT_W+FRAC_W-1:0]     space_word
);
    localparam int BYTE_W = (INT_W + FRAC_W) / 2;
    localparam logic [INT_W-1:0] FLD_MIN = INT_W'(INT_MIN - INT_OFFSET);
    localparam logic [INT_W-1:0] FLD_MAX = INT_W'(INT_MAX - INT_OFFSET);

    logic [INT_W-1:0] wfld;
    logic             all_stable_pre;
    assign wfld = cfg_wdata[BYTE_W-1 -: INT_W];
    assign all_stable_pre = 1'b1;

    AST_ASK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(keying_fsk)) |-> (ratio_word == ctr_word)); // R7
    AST_MARK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(keying_fsk) && $past(tx_bit)) |-> (ratio_word == mark_word)); // R8
    AST_SPACE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(keying_fsk) && !$past(tx_bit)) |-> (ratio_word == space_word)); // R8
    AST_LOW_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_addr[0]) |=> ($stable(ctr_word) && $stable(mark_word) && $stable(space_word))); // R4
    AST_BAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr[0] && ((wfld < FLD_MIN) || (wfld > FLD_MAX)))
        |=> ($stable(ctr_word) && $stable(mark_word) && $stable(space_word))); // R6
    AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_addr[ADDR_W-1:1] == '1))
        |=> ($stable(ctr_word) && $stable(mark_word) && $stable(space_word))); // R3
    AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        all_stable_pre |-> ((ratio_word[INT_W+FRAC_W-1 -: INT_W] >= FLD_MIN) &&
                            (ratio_word[INT_W+FRAC_W-1 -: INT_W] <= FLD_MAX))); // R6
    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        all_stable_pre |-> ((div_value >= DIV_W'(INT_MIN)) && (div_value <= DIV_W'(INT_MAX + 1)))); // R11
endmodule

bind fdw_selector fdw_selector_chk #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .INT_OFFSET(INT_OFFSET),
    .INT_MIN(INT_MIN), .INT_MAX(INT_MAX), .ADDR_W(ADDR_W), .DIV_W(DIV_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .keying_fsk(keying_fsk), .tx_bit(tx_bit),
    .ratio_word(ratio_word), .div_value(div_value), .ctr_word(ctr_word),
    .mark_word(mark_word), .space_word(space_word)
);

// File: tb/tb_fdw_selector.sv
module tb_fdw_selector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        keying_fsk = 1'b0;
    logic        tx_bit = 1'b0;
    logic [15:0] ratio_word;
    logic [4:0]  div_value;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    logic [15:0] m_word [3];
    logic [7:0]  m_stage [3];
    int          m_sel;
    logic [11:0] m_acc;
    int          m_div;

    always #4 clk = ~clk;

    fdw_selector dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .keying_fsk(keying_fsk), .tx_bit(tx_bit),
        .ratio_word(ratio_word), .div_value(div_value)
    );

    function automatic bit legal_high(logic [7:0] b);
        return (b[7:4] >= 4'd3) && (b[7:4] <= 4'd12);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // one reference cycle: inputs already driven at a negedge
    task automatic cycle(string tag);
        logic [15:0] w;
        logic [12:0] s;
        @(posedge clk);
        w = m_word[m_sel];
        s = {1'b0, m_acc} + {1'b0, w[11:0]};
        m_div = 16 + int'(w[15:12]) + int'(s[12]);
        m_acc = s[11:0];
        if (cfg_we && cfg_addr[2:1] != 2'b11) begin
            if (!cfg_addr[0]) m_stage[cfg_addr[2:1]] = cfg_wdata;
            else if (legal_high(cfg_wdata))
                m_word[cfg_addr[2:1]] = {cfg_wdata, m_stage[cfg_addr[2:1]]};
        end
        m_sel = !keying_fsk ? 0 : (tx_bit ? 1 : 2);
        @(negedge clk);
        check(tag, int'(ratio_word), int'(m_word[m_sel]));
        check("R10/R11 divide value", int'(div_value), m_div);
    endtask

    task automatic drive(bit we, int addr, int data, bit fsk, bit bitv);
        cfg_we = we;
        cfg_addr = 3'(addr);
        cfg_wdata = 8'(data);
        keying_fsk = fsk;
        tx_bit = bitv;
    endtask

    initial begin
        int hits;
        void'($urandom(32'd7431));
        for (int i = 0; i < 3; i++) begin
            m_word[i] = 16'h8000;
            m_stage[i] = 8'h00;
        end
        m_sel = 0; m_acc = '0; m_div = 24;
        repeat (3) @(negedge clk);
        check("R1 ratio in reset", int'(ratio_word), 16'h8000);
        check("R1 divide in reset", int'(div_value), 24);
        rst_n = 1'b1;
        drive(0, 0, 0, 0, 0);
        cycle("R1 after release");

        // staging and commit
        drive(1, 0, 8'h34, 0, 0); cycle("R4 low byte staged");
        drive(0, 0, 0, 0, 0);      cycle("R4 still old word");
        check("R4 explicit", int'(ratio_word), 16'h8000);
        drive(1, 1, 8'h5A, 0, 0); cycle("R5 commit");
        check("R5 explicit", int'(ratio_word), 16'h5A34);
        drive(1, 1, 8'hD0, 0, 0); cycle("R6 int 29 refused");
        check("R6 int 29", int'(ratio_word), 16'h5A34);
        drive(1, 1, 8'h20, 0, 0); cycle("R6 int 18 refused");
        check("R6 int 18", int'(ratio_word), 16'h5A34);
        drive(1, 1, 8'h30, 0, 0); cycle("R6 int 19 accepted");
        check("R6 int 19", int'(ratio_word), 16'h3034);
        drive(1, 1, 8'hC0, 0, 0); cycle("R6 int 28 accepted");
        check("R6 int 28", int'(ratio_word), 16'hC034);

        // half fraction: divide alternates (R10)
        drive(1, 0, 8'h00, 0, 0); cycle("R4 stage");
        drive(1, 1, 8'h58, 0, 0); cycle("R5 commit 21.5");
        drive(0, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) cycle("R10 half fraction");

        // fraction of one at the top of range (R2, R11)
        drive(1, 0, 8'h01, 0, 0); cycle("R4 stage");
        drive(1, 1, 8'hC0, 0, 0); cycle("R5 commit 28+1/4096");
        drive(0, 0, 0, 0, 0);
        hits = 0;
        for (int i = 0; i < 4096; i++) begin
            cycle("R2 fine step");
            if (div_value == 5'd29) hits++;
        end
        check("R2 one carry in 4096 cycles", hits, 1);

        // mark and space words, FSK switching
        drive(1, 2, 8'h23, 0, 0); cycle("R3 mark low");
        drive(1, 3, 8'h61, 0, 0); cycle("R3 mark high");
        drive(1, 4, 8'h55, 0, 0); cycle("R3 space low");
        drive(1, 5, 8'h99, 0, 0); cycle("R3 space high");
        drive(0, 0, 0, 1, 1); cycle("R8 mark");
        check("R8 mark explicit", int'(ratio_word), 16'h6123);
        drive(0, 0, 0, 1, 0); cycle("R8 space");
        check("R8 space explicit", int'(ratio_word), 16'h9955);
        drive(0, 0, 0, 0, 1); cycle("R7 center in ASK with data 1");
        check("R7 explicit", int'(ratio_word), 16'hC001);
        // R9: change inputs, output must hold until the edge
        drive(0, 0, 0, 1, 1);
        #1 check("R9 before edge", int'(ratio_word), 16'hC001);
        cycle("R9 after edge");

        // unused addresses
        drive(1, 6, 8'h77, 0, 0); cycle("R3 addr 6 ignored");
        drive(1, 7, 8'h77, 0, 0); cycle("R3 addr 7 ignored");
        drive(0, 0, 0, 0, 0); cycle("R3 center unchanged");
        drive(0, 0, 0, 1, 1); cycle("R3 mark unchanged");
        drive(0, 0, 0, 1, 0); cycle("R3 space unchanged");

        // seeded random run
        for (int i = 0; i < 3000; i++) begin
            bit we;
            int addr, data;
            we = ($urandom % 10) < 3;
            addr = int'($urandom % 8);
            data = int'($urandom % 256);
            drive(we, addr, data, ($urandom % 4) != 0, $urandom % 2);
            cycle(keying_fsk ? "R8 random select" : "R7 random select");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule